// File: doc/BRIEF.md
# Ring Oscillator Phase Decoder with Modulo Differentiator

This block sits behind the sampling flip-flops of an odd-length pseudo-differential ring oscillator used as a first-order noise-shaping quantizer. Each sample clock, when a strobe marks the snapshot as valid, it receives two bits per ring element: the sampled positive-side output and the sampled negative-side output. In a healthy ring exactly one element is in a transition state at any instant. The block finds that element and its level, and turns the pair into a phase number that counts in steps of one 2N-th of an oscillator cycle.

The phase number is already reduced modulo one cycle. The block takes its first difference against the phase of the previous legal snapshot and wraps the result modulo one cycle again. Because of this second wrap, the first wrap leaves no trace in the output. The result is a registered unsigned code, the first-order noise-shaped sample of the converter.

Snapshots that match none of the 2N legal ring states raise a one-cycle error pulse and leave the stored phase untouched. The first legal snapshot after reset only seeds the stored phase.

Top module: `ring_phase_decoder`

## Requirements
- R1: Input layout. Bit k of `pos_bits` and `neg_bits` is the sampled positive-side and negative-side output of ring element k. The input of element k is the output of element k-1, and the input of element 0 is the output of element N-1 (N = 15 by default, 30 input bits).
- R2: A snapshot is legal only when two conditions hold. First, `neg_bits` is the bitwise complement of `pos_bits`. Second, exactly one element k has its input level equal to its output level (pos[k-1] == pos[k], indices modulo N). A snapshot with any other shape is illegal.
- R3: For a legal snapshot, with k the transition element and v its shared positive-side level (0 or 1), the phase number is k when k mod 2 equals v, and k+N otherwise. This covers 0 to 2N-1, and each consecutive phase moves the transition one element forward and flips v.
- R4: One clock after a legal valid snapshot (with a previous legal phase stored), `out_valid` is 1 and `out_code` = (phase_new - phase_prev) mod 2N. The code is 5 bits wide by default and always below 2N.
- R5: The first legal valid snapshot after reset gives no `out_valid`; it only stores its phase. Illegal snapshots do not count as this first one.
- R6: One clock after an illegal valid snapshot, `err_flag` is 1 for one cycle and `out_valid` is 0. The stored phase is kept, so the next legal output is measured against the last legal phase.
- R7: A cycle with `in_valid` low gives `out_valid` and `err_flag` low on the next clock and does not alter the stored phase, whatever the ring bits are.
- R8: While reset is asserted, `out_valid`, `err_flag` and `out_code` are 0. Reset is asynchronous active-low and its release is synchronized over two clocks.
- R9: Differences that cross the cycle boundary wrap: 29 followed by 0 gives code 1, and a repeated phase gives code 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Sample clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Snapshot on the ring inputs is to be decoded |
| pos_bits | input | 15 | Sampled positive-side outputs, bit k = element k |
| neg_bits | input | 15 | Sampled negative-side outputs, bit k = element k |
| out_valid | output | 1 | `out_code` holds a new differentiated sample |
| out_code | output | 5 | Wrapped first difference of phase, 0 to 29 |
| err_flag | output | 1 | Previous valid snapshot was not a legal ring state |

## Verification
The assertions assume that the ring inputs change only between clock edges and that `in_valid` is a clean level. They make no assumption about pattern legality, since illegal patterns are part of the defined behaviour. The stimulus builds every legal snapshot from a phase number using the ring's own propagation rule, with the negative side as the exact complement of the positive side. Illegal cases are deliberate: an all-low positive side and a negative side that fails to complement. All inputs are changed on the falling clock edge.

// File: rtl/ringph_pkg.sv
package ringph_pkg;

  localparam int unsigned RING_ELEMS_DEF = 15;

  // (a - b) reduced into 0 .. m-1, for a and b already inside that range
  function automatic int wrap_sub(input int a, input int b, input int m);
    int t;
    t = a - b;
    if (t < 0) t = t + m;
    return t;
  endfunction

endpackage

// File: rtl/ringph_xition_detect.sv
module ringph_xition_detect #(
  parameter int unsigned N = ringph_pkg::RING_ELEMS_DEF
) (
  input  logic [N-1:0] pos_i,
  input  logic [N-1:0] neg_i,
  output logic [N-1:0] low_flag_o,
  output logic [N-1:0] high_flag_o,
  output logic         sides_ok_o
);

  // each element looks at its own output and the output driving its input
  for (genvar k = 0; k < N; k++) begin : g_elem
    localparam int unsigned PREV = (k + N - 1) % N;
    assign low_flag_o[k]  = ~pos_i[PREV] & ~pos_i[k] &  neg_i[PREV] &  neg_i[k];
    assign high_flag_o[k] =  pos_i[PREV] &  pos_i[k] & ~neg_i[PREV] & ~neg_i[k];
  end

  assign sides_ok_o = &(pos_i ^ neg_i);

endmodule

// File: rtl/ringph_phase_encode.sv
module ringph_phase_encode #(
  parameter int unsigned N = ringph_pkg::RING_ELEMS_DEF
) (
  input  logic [N-1:0]              low_flag_i,
  input  logic [N-1:0]              high_flag_i,
  input  logic                      sides_ok_i,
  output logic [$clog2(2*N)-1:0]    phase_o,
  output logic                      legal_o
);

  localparam int unsigned W  = $clog2(2*N);
  localparam int unsigned CW = $clog2(2*N + 1);

  logic [CW-1:0] hits;
  logic [W-1:0]  ph;

  always_comb begin
    hits = '0;
    ph   = '0;
    for (int k = 0; k < int'(N); k++) begin
      if (low_flag_i[k]) begin
        hits = hits + CW'(1);
        ph   = ph | ((k % 2 == 0) ? W'(k) : W'(k + int'(N)));
      end
      if (high_flag_i[k]) begin
        hits = hits + CW'(1);
        ph   = ph | ((k % 2 == 1) ? W'(k) : W'(k + int'(N)));
      end
    end
  end

  assign legal_o = sides_ok_i && (hits == CW'(1));
  assign phase_o = ph;

endmodule

// File: rtl/ringph_wrap_diff.sv
module ringph_wrap_diff #(
  parameter int unsigned N = ringph_pkg::RING_ELEMS_DEF
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   sample_en,
  input  logic                   legal_i,
  input  logic [$clog2(2*N)-1:0] phase_i,
  output logic [$clog2(2*N)-1:0] code_o,
  output logic                   valid_o,
  output logic                   err_o,
  output logic [$clog2(2*N)-1:0] phase_q_o
);

  localparam int unsigned P = 2 * N;
  localparam int unsigned W = $clog2(P);

  logic [W-1:0] phase_q, phase_d;
  logic [W-1:0] code_q, code_d;
  logic         primed_q, primed_d;
  logic         valid_q, valid_d;
  logic         err_q, err_d;
  logic         phase_en, code_en;

  always_comb begin
    phase_d  = phase_i;
    primed_d = 1'b1;
    code_d   = W'(ringph_pkg::wrap_sub(int'(phase_i), int'(phase_q), int'(P)));
    phase_en = sample_en && legal_i;
    code_en  = phase_en && primed_q;
    valid_d  = code_en;
    err_d    = sample_en && !legal_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q  <= '0;
      primed_q <= 1'b0;
    end else if (phase_en) begin
      phase_q  <= phase_d;
      primed_q <= primed_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      code_q <= '0;
    end else if (code_en) begin
      code_q <= code_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q <= 1'b0;
      err_q   <= 1'b0;
    end else begin
      valid_q <= valid_d;
      err_q   <= err_d;
    end
  end

  assign code_o    = code_q;
  assign valid_o   = valid_q;
  assign err_o     = err_q;
  assign phase_q_o = phase_q;

endmodule

// File: rtl/ring_phase_decoder.sv
module ring_phase_decoder #(
  parameter int unsigned N = ringph_pkg::RING_ELEMS_DEF
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   in_valid,
  input  logic [N-1:0]           pos_bits,
  input  logic [N-1:0]           neg_bits,
  output logic                   out_valid,
  output logic [$clog2(2*N)-1:0] out_code,
  output logic                   err_flag
);

  localparam int unsigned P = 2 * N;
  localparam int unsigned W = $clog2(P);

  // reset: asserted asynchronously, released on the second clock edge
  logic [1:0] rst_pipe;
  logic       rst_sync_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_sync_n = rst_pipe[1];

  logic [N-1:0] low_flag, high_flag;
  logic         sides_ok;
  logic [W-1:0] phase_enc;
  logic         legal;
  logic [W-1:0] phase_q;

  ringph_xition_detect #(.N(N)) u_detect (
    .pos_i      (pos_bits),
    .neg_i      (neg_bits),
    .low_flag_o (low_flag),
    .high_flag_o(high_flag),
    .sides_ok_o (sides_ok)
  );

  ringph_phase_encode #(.N(N)) u_encode (
    .low_flag_i (low_flag),
    .high_flag_i(high_flag),
    .sides_ok_i (sides_ok),
    .phase_o    (phase_enc),
    .legal_o    (legal)
  );

  ringph_wrap_diff #(.N(N)) u_diff (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .sample_en(in_valid),
    .legal_i  (legal),
    .phase_i  (phase_enc),
    .code_o   (out_code),
    .valid_o  (out_valid),
    .err_o    (err_flag),
    .phase_q_o(phase_q)
  );

endmodule

// File: rtl/ring_phase_decoder_chk.sv
module ring_phase_decoder_chk #(
  parameter int unsigned W = 5,
  parameter int unsigned P = 30
) (
  input logic         clk,
  input logic         rst_n,
  input logic         in_valid,
  input logic         out_valid,
  input logic         err_flag,
  input logic [W-1:0] out_code,
  input logic [W-1:0] phase_q
);

  p_code_range_r4: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (out_code < W'(P)));

  p_valid_after_strobe_r4: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> (out_valid || err_flag || $stable(out_code)));

  p_err_blocks_valid_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !(out_valid && err_flag));

  p_phase_held_r6: assert property (@(posedge clk) disable iff (!rst_n)
    err_flag |-> $stable(phase_q));

  p_idle_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> (!out_valid && !err_flag && $stable(phase_q)));

endmodule

bind ring_phase_decoder ring_phase_decoder_chk #(.W(W), .P(P)) u_chk (
  .clk      (clk),
  .rst_n    (rst_sync_n),
  .in_valid (in_valid),
  .out_valid(out_valid),
  .err_flag (err_flag),
  .out_code (out_code),
  .phase_q  (phase_q)
);

// File: tb/ring_phase_decoder_bench.sv
module ring_phase_decoder_bench;

  localparam int N = 15;
  localparam int P = 2 * N;
  localparam int W = $clog2(P);

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         in_valid = 1'b0;
  logic [N-1:0] pos_bits = '0;
  logic [N-1:0] neg_bits = '1;
  logic         out_valid;
  logic [W-1:0] out_code;
  logic         err_flag;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #5 clk = ~clk;

  ring_phase_decoder #(.N(N)) u_ring_phase_decoder (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid),
    .pos_bits(pos_bits), .neg_bits(neg_bits),
    .out_valid(out_valid), .out_code(out_code), .err_flag(err_flag)
  );

  // phase j -> positive-side snapshot: transition element j mod N at level j mod 2,
  // each following element inverts its input
  function automatic logic [N-1:0] ring_pat(input int j);
    logic [N-1:0] r;
    int  k;
    logic v;
    k = j % N;
    v = (j % 2) == 1;
    for (int m = 0; m < N; m++) r[(k + m) % N] = v ^ ((m % 2) == 1);
    return r;
  endfunction

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic step(input logic v, input logic [N-1:0] p, input logic [N-1:0] n);
    @(negedge clk);
    in_valid = v;
    pos_bits = p;
    neg_bits = n;
    @(posedge clk);
    #1;
  endtask

  task automatic step_phase(input int j);
    step(1'b1, ring_pat(j), ~ring_pat(j));
  endtask

  // {phase, expected code}; first row only seeds the phase
  localparam int VEC [12][2] = '{
    '{0, 0}, '{3, 3}, '{3, 0}, '{10, 7}, '{29, 19}, '{1, 2},
    '{15, 14}, '{14, 29}, '{7, 23}, '{22, 15}, '{0, 8}, '{28, 28}
  };

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    chk("R8 reset out_valid", int'(out_valid), 0);
    chk("R8 reset err_flag", int'(err_flag), 0);
    chk("R8 reset out_code", int'(out_code), 0);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(posedge clk);

    // table walk: R1 layout, R3 mapping, R4 difference
    for (int i = 0; i < 12; i++) begin
      step_phase(VEC[i][0]);
      if (i == 0) begin
        chk("R5 first sample suppressed", int'(out_valid), 0);
      end else begin
        chk("R4 out_valid", int'(out_valid), 1);
        chk("R3 R4 out_code", int'(out_code), VEC[i][1]);
      end
    end

    // R3 sweep: every phase in order advances by one step
    for (int j = 29; j <= 60; j++) begin
      step_phase(j % P);
      chk("R3 sweep code", int'(out_code), 1);
    end
    // now last legal phase = 0

    // R2 illegal: all-low positive side has many equal neighbours
    step(1'b1, '0, '1);
    chk("R2 R6 err on illegal", int'(err_flag), 1);
    chk("R6 no valid on illegal", int'(out_valid), 0);
    step_phase(5);
    chk("R6 phase held across illegal", int'(out_code), 5);
    chk("R6 err is one cycle", int'(err_flag), 0);

    // R2 illegal: negative side not the complement
    step(1'b1, ring_pat(9), ring_pat(9));
    chk("R2 side mismatch err", int'(err_flag), 1);
    step_phase(9);
    chk("R2 after mismatch code", int'(out_code), 4);

    // R7 idle cycle with a legal pattern present
    step(1'b0, ring_pat(20), ~ring_pat(20));
    chk("R7 idle no valid", int'(out_valid), 0);
    chk("R7 idle no err", int'(err_flag), 0);
    step(1'b0, '0, '0);
    chk("R7 idle illegal no err", int'(err_flag), 0);
    step_phase(21);
    chk("R7 idle left phase", int'(out_code), 12);

    // R9 wrap and repeat
    step_phase(29);
    chk("R9 to top", int'(out_code), 8);
    step_phase(0);
    chk("R9 wrap 29 to 0", int'(out_code), 1);
    step_phase(0);
    chk("R9 repeated phase", int'(out_code), 0);

    // R8 / R5 reset mid-run
    @(negedge clk);
    in_valid = 1'b0;
    rst_n = 1'b0;
    #1;
    chk("R8 async reset valid", int'(out_valid), 0);
    chk("R8 async reset code", int'(out_code), 0);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(posedge clk);
    step(1'b1, '1, '0);
    chk("R5 illegal after reset err", int'(err_flag), 1);
    step_phase(12);
    chk("R5 first legal suppressed", int'(out_valid), 0);
    step_phase(17);
    chk("R5 second legal valid", int'(out_valid), 1);
    chk("R5 second legal code", int'(out_code), 5);

    step(1'b0, '0, '1);
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule